// File: doc/BRIEF.md
# Two-Stage Prescaled Event Timer

This block is a free-running timer built for a high clock rate. The count is split into two parts. The low part is a ring of flops holding one hot bit, which moves one place on every enabled cycle. The high part is a binary counter, and it advances only when the hot bit leaves the last ring place. Because of this, the high counter's carry path has a whole ring revolution to settle, instead of the single cycle that one wide adder would get.

Both stages share one clock. The high stage is steered by a clock enable taken from the ring, never by a derived clock. A run input starts and stops counting. A capture strobe latches the combined count, which is the high count followed by the binary index of the ring place, so it forms one monotonic binary time. A sticky flag records that the full count has wrapped.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, the ring holds its hot bit at place 0, the high count is zero, `overflow` is 0 and `cap_time` is 0. A capture taken straight after reset returns 0.
- R2: Each rising edge with `run` high advances the combined count `{high, ring index}` by exactly one. The ring always holds exactly one hot bit.
- R3: On an edge with `run` low, neither the ring nor the high count changes.
- R4: The high count rises by one only on an enabled edge where the hot bit sits in the last ring place (index RING_LEN-1). On every other edge it holds. The low field of the time therefore goes from 3 to 0 exactly when the high field steps.
- R5: On an edge where `capture` is high, `cap_time` takes the combined count as it stood just before that edge, before any advance made on the same edge.
- R6: On an edge where `capture` is low, `cap_time` keeps its value.
- R7: `overflow` goes to 1 on an enabled edge where the high count is all ones and the hot bit is in the last place. It then stays at 1 until reset.
- R8: After its maximum value (all ones), the combined count returns to zero.
- R9: A capture taken while `run` is low returns the held count. Capture works independently of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both stages |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Count enable |
| capture | input | 1 | Latch strobe for the combined count |
| cap_time | output | HIGH_W+log2(RING_LEN) (24 by default) | Latched time value: high count in the upper bits, ring index in the lower bits |
| overflow | output | 1 | Sticky flag for a full wrap of the count |

## Verification
The bench goes after the point where the ring returns from its last place to place 0. A design that steps the high stage one place early or late shows up there as a duplicated or skipped time value across consecutive captures. It drives the count all the way to its top value, using a narrower high stage, so that the wrap to zero and the sticky flag can be checked. A flag set one cycle off, or cleared again by later counting, fails those checks. Captures made on the same edge as an advance are checked for the value before that edge. Captures made while stopped are checked for an unchanged count, which catches a design that keeps counting while `run` is low.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Binary index of the single set bit in a one-hot vector (0 when empty).
  function automatic int unsigned ring_slot(input logic [31:0] onehot);
    int unsigned idx;
    idx = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (onehot[k]) idx = k;
    end
    return idx;
  endfunction

  // Combined time: upper stage concatenated above the ring index.
  function automatic logic [63:0] join_time(input logic [31:0] upper,
                                            input int unsigned slot,
                                            input int unsigned slot_bits);
    return (64'(upper) << slot_bits) | 64'(slot);
  endfunction

endpackage

// File: rtl/evt_ring_prescaler.sv
module evt_ring_prescaler #(
  parameter int RING_LEN = 4,
  localparam int ENC_W = $clog2(RING_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  output logic [RING_LEN-1:0] ring,
  output logic [ENC_W-1:0]    slot,
  output logic                wrap
);
  import evt_timer_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)      ring <= RING_LEN'(1);
    else if (run) ring <= {ring[RING_LEN-2:0], ring[RING_LEN-1]};
  end

  assign slot = ENC_W'(ring_slot(32'(ring)));
  // Enable for the upper stage: hot bit leaves the last place this edge.
  assign wrap = run && ring[RING_LEN-1];

  assert_single_hot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1);

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(ring));

  assert_ring_returns_home_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ring[0]);

endmodule

// File: rtl/evt_high_counter.sv
module evt_high_counter #(
  parameter int HIGH_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [HIGH_W-1:0] high,
  output logic              ovf
);
  logic at_top;
  logic top_hit;

  assign at_top  = &high;
  assign top_hit = adv && at_top;

  always_ff @(posedge clk) begin
    if (rst)      high <= '0;
    else if (adv) high <= high + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (top_hit) ovf <= 1'b1;
  end

  assert_step_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    adv |=> high == $past(high) + 1'b1);

  assert_hold_off_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(high));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  assert_overflow_on_top_R7: assert property (@(posedge clk) disable iff (rst)
    top_hit |=> ovf && high == '0);

endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [TIME_W-1:0] live,
  output logic [TIME_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (strobe) held <= live;
  end

  assert_latch_live_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> held == $past(live));

  assert_keep_value_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(held));

endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int RING_LEN = 4,
  parameter int HIGH_W   = 22,
  localparam int ENC_W   = $clog2(RING_LEN),
  localparam int TIME_W  = HIGH_W + ENC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              capture,
  output logic [TIME_W-1:0] cap_time,
  output logic              overflow
);
  import evt_timer_pkg::*;

  logic [RING_LEN-1:0] ring;
  logic [ENC_W-1:0]    slot;
  logic                ring_wrap;
  logic [HIGH_W-1:0]   high;
  logic [TIME_W-1:0]   live_time;

  evt_ring_prescaler #(.RING_LEN(RING_LEN)) u_ring (
    .clk (clk), .rst (rst), .run (run),
    .ring(ring), .slot(slot), .wrap(ring_wrap)
  );

  evt_high_counter #(.HIGH_W(HIGH_W)) u_high (
    .clk(clk), .rst(rst), .adv(ring_wrap), .high(high), .ovf(overflow)
  );

  assign live_time = TIME_W'(join_time(32'(high), int'(slot), ENC_W));

  evt_capture #(.TIME_W(TIME_W)) u_cap (
    .clk(clk), .rst(rst), .strobe(capture), .live(live_time), .held(cap_time)
  );

  assert_count_steps_R2: assert property (@(posedge clk) disable iff (rst)
    run |=> live_time == $past(live_time) + 1'b1);

  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(live_time));

endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int RL = 4;
  localparam int HW = 10;
  localparam int TW = HW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic capture = 1'b0;
  logic [TW-1:0] cap_time;
  logic overflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [TW-1:0] m_cnt, m_cap;
  logic m_ovf;

  always #5 clk = ~clk;

  evt_timer #(.RING_LEN(RL), .HIGH_W(HW)) uut (
    .clk(clk), .rst(rst), .run(run), .capture(capture),
    .cap_time(cap_time), .overflow(overflow)
  );

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic bit is_top(input logic [TW-1:0] c);
    return c == {TW{1'b1}};
  endfunction

  task automatic check_val(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cap_time actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_flag(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s overflow actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one rising edge, then checks.
  task automatic step(input bit r, input bit s, input string tag);
    run = r;
    capture = s;
    @(posedge clk);
    if (s) m_cap = m_cnt;
    if (r) begin
      if (is_top(m_cnt)) m_ovf = 1'b1;
      m_cnt = advance(m_cnt);
    end
    @(negedge clk);
    check_val(tag, cap_time, m_cap);
    check_flag("R7", overflow, m_ovf);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run = 1'b0;
    capture = 1'b0;
    repeat (2) @(negedge clk);
    m_cnt = '0;
    m_cap = '0;
    m_ovf = 1'b0;
    rst = 1'b0;
    check_val("R1", cap_time, '0);
    check_flag("R1", overflow, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();
    // R1: first capture returns zero
    step(1'b0, 1'b1, "R1");
    // R2 and R4: back-to-back captures across two ring revolutions
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R4");
    // R3 and R9: stopped, captures keep returning the same count
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R3");
    // R2: single enabled edge
    step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, "R2");
    // R5 and R6: mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      bit r = ($urandom % 4) != 0;
      bit s = ($urandom % 5) == 0;
      step(r, s, s ? "R5" : "R6");
    end
    // R8: run up to the top and across the wrap
    while (m_cnt != TW'(4092)) step(1'b1, 1'b0, "R6");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R8");
    // R7: flag stays after further counting
    for (int i = 0; i < 40; i++) step(($urandom % 2) == 0, ($urandom % 3) == 0, "R7");
    // R1: reset clears the flag and the count
    do_reset();
    step(1'b1, 1'b1, "R1");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule